// File: doc/BRIEF.md
# DS3 C-Bit Overhead Receiver

This block sits behind a DS3 framer that is already aligned. It watches the C-bit positions of each received M-frame and pulls out the maintenance overhead that C-bit parity framing carries. The framer marks each C-bit position with a one-cycle strobe and gives its subframe number (1..7) and its position within the subframe (1..3). The framer also supplies an in-frame flag and the parity it computed over the previous frame's payload.

The block does five jobs. It decides whether the far end runs C-bit parity framing, using the identifier bit in subframe 1. It recovers the triple-copied parity from subframe 3 by 2-of-3 majority and compares it with the local parity. It turns the 3-bit far-end error field in subframe 4 into an error pulse and a saturating count. It forwards the FEAC bit once per frame and the three data-link bits of subframe 5 as strobed serial streams. Decoding of FEAC codewords and HDLC frames happens downstream.

Top module: `cbit_overhead_rx`

## Requirements
- R1: After reset, modeDet, cpValue, cpErr, febeErr, feacValid, dlValid, feacBit, dlBit are 0 and febeCount is 0.
- R2: The identifier bit is sampled at the strobe with slotSub=1, slotIdx=1. modeDet rises one cycle after the 3rd consecutive sample of 1. It falls one cycle after the 3rd consecutive sample of 0. A sample of the opposite value restarts the run.
- R3: On the strobe with slotSub=3, slotIdx=3, the bits from slotIdx 1, 2 and 3 of subframe 3 are combined by 2-of-3 majority. One cycle later cpValue holds the result. cpValue changes at no other time.
- R4: cpErr is a one-cycle pulse, one cycle after the slotSub=3, slotIdx=3 strobe. It fires when the majority value differs from localParity sampled on that same strobe.
- R5: The far-end error field is the subframe 4 bits in slotIdx order 1,2,3. febeErr is a one-cycle pulse, one cycle after the slotSub=4, slotIdx=3 strobe, whenever that field is not 111. This includes 000, the pattern sent by a far end that is out of frame.
- R6: febeCount (CNT_W bits, default 16) goes up by one, on the same cycle as each febeErr pulse. It holds at all ones.
- R7: A cntLatch pulse clears febeCount on the next cycle. If an increment happens on the same cycle, the clear wins.
- R8: One cycle after the slotSub=1, slotIdx=3 strobe, feacValid pulses for one cycle and feacBit carries that slot's bit.
- R9: One cycle after each strobe with slotSub=5 (slotIdx 1, 2 and 3 in turn), dlValid pulses and dlBit carries that slot's bit.
- R10: While inFrame is low at a strobe, that strobe produces no output pulse and no cpValue update. A mode sample taken then neither advances nor breaks a mode run.
- R11: Strobes for subframes 2, 6 and 7, and for slotSub=1, slotIdx=2, produce no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxBit | input | 1 | Received bit in the current C-bit slot |
| slotStb | input | 1 | One-cycle mark of a C-bit slot |
| slotSub | input | 3 | Subframe number 1..7 |
| slotIdx | input | 2 | C-bit position 1..3 within the subframe |
| inFrame | input | 1 | Framer is aligned |
| localParity | input | 1 | Local payload parity of the previous frame |
| cntLatch | input | 1 | Clear pulse for the far-end error count |
| modeDet | output | 1 | Far end uses C-bit parity framing |
| cpValue | output | 1 | Majority-voted received parity |
| cpErr | output | 1 | Parity mismatch pulse |
| febeErr | output | 1 | Far-end block error pulse |
| febeCount | output | CNT_W | Saturating far-end error count |
| feacBit | output | 1 | FEAC serial bit |
| feacValid | output | 1 | FEAC bit strobe |
| dlBit | output | 1 | Data-link serial bit |
| dlValid | output | 1 | Data-link bit strobe |

## Verification
Counter saturation is the hardest case to reach, because it needs tens of thousands of errored frames at the default width. The bench therefore builds the block with an 8-bit count and sends back-to-back subframe 4 bursts until the count is pinned at all ones. Two other cases need dedicated stimulus: an out-of-frame strobe in the middle of a mode run, and a clear pulse on the same cycle as an increment. Directed sequences cover both. Seeded random frames with occasional out-of-frame slots then cover the remaining combinations against a bench model.

// File: rtl/cbit_rx_pkg.sv
package cbit_rx_pkg;
  localparam int SUB_W = 3;
  localparam int IDX_W = 2;

  // Strobes from control to datapath, one per decoded slot event.
  typedef struct packed {
    logic cpCap1;
    logic cpCap2;
    logic cpEval;
    logic feCap1;
    logic feCap2;
    logic feEval;
    logic feacStb;
    logic dlStb;
  } strobe_t;
endpackage

// File: rtl/cbit_rx_ctrl.sv
module cbit_rx_ctrl
  import cbit_rx_pkg::*;
#(
  parameter int MODE_RUN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxBit,
  input  logic             slotStb,
  input  logic [SUB_W-1:0] slotSub,
  input  logic [IDX_W-1:0] slotIdx,
  input  logic             inFrame,
  output strobe_t          stb,
  output logic             modeDet
);
  localparam int RUN_W = $clog2(MODE_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MODE_RUN);

  logic [RUN_W-1:0] oneRun, zeroRun, oneNext, zeroNext;
  logic modeSmp;

  function automatic logic hit(input logic [SUB_W-1:0] s, input logic [IDX_W-1:0] i,
                               input logic [SUB_W-1:0] ws, input logic [IDX_W-1:0] wi);
    return (s == ws) && (i == wi);
  endfunction

  always_comb begin
    stb         = '0;
    stb.cpCap1  = slotStb && hit(slotSub, slotIdx, 3'd3, 2'd1);
    stb.cpCap2  = slotStb && hit(slotSub, slotIdx, 3'd3, 2'd2);
    stb.cpEval  = slotStb && inFrame && hit(slotSub, slotIdx, 3'd3, 2'd3);
    stb.feCap1  = slotStb && hit(slotSub, slotIdx, 3'd4, 2'd1);
    stb.feCap2  = slotStb && hit(slotSub, slotIdx, 3'd4, 2'd2);
    stb.feEval  = slotStb && inFrame && hit(slotSub, slotIdx, 3'd4, 2'd3);
    stb.feacStb = slotStb && inFrame && hit(slotSub, slotIdx, 3'd1, 2'd3);
    stb.dlStb   = slotStb && inFrame && (slotSub == 3'd5) && (slotIdx != 2'd0);
    modeSmp     = slotStb && inFrame && hit(slotSub, slotIdx, 3'd1, 2'd1);
  end

  always_comb begin
    oneNext  = '0;
    zeroNext = '0;
    if (rxBit) oneNext  = (oneRun  == RUN_MAX) ? RUN_MAX : oneRun + 1'b1;
    else       zeroNext = (zeroRun == RUN_MAX) ? RUN_MAX : zeroRun + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oneRun  <= '0;
      zeroRun <= '0;
      modeDet <= 1'b0;
    end else if (modeSmp) begin
      oneRun  <= oneNext;
      zeroRun <= zeroNext;
      if (oneNext == RUN_MAX)  modeDet <= 1'b1;
      if (zeroNext == RUN_MAX) modeDet <= 1'b0;
    end
  end
endmodule

// File: rtl/cbit_rx_dp.sv
module cbit_rx_dp
  import cbit_rx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic             rxBit,
  input  logic             localParity,
  input  logic             cntLatch,
  output logic             cpValue,
  output logic             cpErr,
  output logic             febeErr,
  output logic [CNT_W-1:0] febeCount,
  output logic             feacBit,
  output logic             feacValid,
  output logic             dlBit,
  output logic             dlValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [1:0] cpHeld, feHeld;
  logic       cpMaj, feBad;

  assign cpMaj = (cpHeld[0] & cpHeld[1]) | (cpHeld[0] & rxBit) | (cpHeld[1] & rxBit);
  assign feBad = ~(feHeld[0] & feHeld[1] & rxBit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpHeld <= '0;
      feHeld <= '0;
    end else begin
      if (stb.cpCap1) cpHeld[0] <= rxBit;
      if (stb.cpCap2) cpHeld[1] <= rxBit;
      if (stb.feCap1) feHeld[0] <= rxBit;
      if (stb.feCap2) feHeld[1] <= rxBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpValue   <= 1'b0;
      cpErr     <= 1'b0;
      febeErr   <= 1'b0;
      febeCount <= '0;
      feacBit   <= 1'b0;
      feacValid <= 1'b0;
      dlBit     <= 1'b0;
      dlValid   <= 1'b0;
    end else begin
      cpErr     <= stb.cpEval && (cpMaj != localParity);
      febeErr   <= stb.feEval && feBad;
      feacValid <= stb.feacStb;
      dlValid   <= stb.dlStb;
      if (stb.cpEval)  cpValue <= cpMaj;
      if (stb.feacStb) feacBit <= rxBit;
      if (stb.dlStb)   dlBit   <= rxBit;
      if (cntLatch)
        febeCount <= '0;
      else if (stb.feEval && feBad && febeCount != CNT_MAX)
        febeCount <= febeCount + 1'b1;
    end
  end
endmodule

// File: rtl/cbit_overhead_rx.sv
module cbit_overhead_rx
  import cbit_rx_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int MODE_RUN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxBit,
  input  logic             slotStb,
  input  logic [2:0]       slotSub,
  input  logic [1:0]       slotIdx,
  input  logic             inFrame,
  input  logic             localParity,
  input  logic             cntLatch,
  output logic             modeDet,
  output logic             cpValue,
  output logic             cpErr,
  output logic             febeErr,
  output logic [CNT_W-1:0] febeCount,
  output logic             feacBit,
  output logic             feacValid,
  output logic             dlBit,
  output logic             dlValid
);
  strobe_t stb;

  cbit_rx_ctrl #(.MODE_RUN(MODE_RUN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rxBit(rxBit), .slotStb(slotStb),
    .slotSub(slotSub), .slotIdx(slotIdx), .inFrame(inFrame),
    .stb(stb), .modeDet(modeDet)
  );

  cbit_rx_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .rxBit(rxBit),
    .localParity(localParity), .cntLatch(cntLatch),
    .cpValue(cpValue), .cpErr(cpErr), .febeErr(febeErr), .febeCount(febeCount),
    .feacBit(feacBit), .feacValid(feacValid), .dlBit(dlBit), .dlValid(dlValid)
  );
endmodule

// File: rtl/cbit_overhead_rx_chk.sv
module cbit_overhead_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rxBit,
  input logic             slotStb,
  input logic [2:0]       slotSub,
  input logic [1:0]       slotIdx,
  input logic             inFrame,
  input logic             localParity,
  input logic             cntLatch,
  input logic             modeDet,
  input logic             cpValue,
  input logic             cpErr,
  input logic             febeErr,
  input logic [CNT_W-1:0] febeCount,
  input logic             feacBit,
  input logic             feacValid,
  input logic             dlBit,
  input logic             dlValid
);
  assert_mode_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(modeDet) |-> $past(slotStb && inFrame && slotSub == 3'd1 && slotIdx == 2'd1));

  assert_cp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpValue) |-> $past(slotStb && inFrame && slotSub == 3'd3 && slotIdx == 2'd3));

  assert_cp_err_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpErr |-> $past(slotStb && inFrame && slotSub == 3'd3 && slotIdx == 2'd3));

  assert_febe_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    febeErr |-> $past(slotStb && inFrame && slotSub == 3'd4 && slotIdx == 2'd3));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cntLatch) |-> (febeCount == $past(febeCount) || febeCount == $past(febeCount) + 1'b1));

  assert_count_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cntLatch) |-> febeCount == '0);

  assert_feac_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    feacValid |-> $past(slotStb && inFrame && slotSub == 3'd1 && slotIdx == 2'd3));

  assert_dl_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dlValid |-> $past(slotStb && inFrame && slotSub == 3'd5));
endmodule

bind cbit_overhead_rx cbit_overhead_rx_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cbit_overhead_rx_tb.sv
module cbit_overhead_rx_tb;
  localparam int CNT_W = 8;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, rxBit, slotStb, inFrame, localParity, cntLatch;
  logic [2:0] slotSub;
  logic [1:0] slotIdx;
  logic modeDet, cpValue, cpErr, febeErr, feacBit, feacValid, dlBit, dlValid;
  logic [CNT_W-1:0] febeCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  int  oneRun = 0, zeroRun = 0, expCount = 0;
  bit  expMode = 0, expCp = 0, cp1 = 0, cp2 = 0, fe1 = 0, fe2 = 0;
  bit  expFeacBit = 0, expDlBit = 0;

  always #10 clk = ~clk;

  cbit_overhead_rx #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rxBit(rxBit), .slotStb(slotStb), .slotSub(slotSub),
    .slotIdx(slotIdx), .inFrame(inFrame), .localParity(localParity), .cntLatch(cntLatch),
    .modeDet(modeDet), .cpValue(cpValue), .cpErr(cpErr), .febeErr(febeErr),
    .febeCount(febeCount), .feacBit(feacBit), .feacValid(feacValid),
    .dlBit(dlBit), .dlValid(dlValid)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit maj3(bit a, bit b, bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic slot(int sub, int idx, bit b, bit inF, bit lp, bit lat);
    bit eCpErr = 0, eFebe = 0, eFeac = 0, eDl = 0;
    string ig;
    slotStb = 1; slotSub = sub[2:0]; slotIdx = idx[1:0]; rxBit = b;
    inFrame = inF; localParity = lp; cntLatch = lat;
    if (sub == 3 && idx == 1) cp1 = b;
    if (sub == 3 && idx == 2) cp2 = b;
    if (sub == 4 && idx == 1) fe1 = b;
    if (sub == 4 && idx == 2) fe2 = b;
    if (inF) begin
      if (sub == 1 && idx == 1) begin
        if (b) begin zeroRun = 0; if (oneRun < 3) oneRun++; if (oneRun == 3) expMode = 1; end
        else   begin oneRun = 0; if (zeroRun < 3) zeroRun++; if (zeroRun == 3) expMode = 0; end
      end
      if (sub == 1 && idx == 3) begin eFeac = 1; expFeacBit = b; end
      if (sub == 3 && idx == 3) begin expCp = maj3(cp1, cp2, b); eCpErr = (expCp != lp); end
      if (sub == 4 && idx == 3) eFebe = !(fe1 && fe2 && b);
      if (sub == 5) begin eDl = 1; expDlBit = b; end
    end
    if (lat) expCount = 0;
    else if (eFebe && expCount != CMAX) expCount++;
    ig = !inF ? "R10" : ((sub == 2 || sub == 6 || sub == 7 || (sub == 1 && idx == 2)) ? "R11" : "");
    @(negedge clk);
    slotStb = 0; cntLatch = 0;
    chk({"R2 modeDet ", ig}, modeDet, expMode);
    chk({"R3 cpValue ", ig}, cpValue, expCp);
    chk({"R4 cpErr ", ig}, cpErr, eCpErr);
    chk({"R5 febeErr ", ig}, febeErr, eFebe);
    chk(lat ? "R7 febeCount clear" : "R6 febeCount", febeCount, expCount);
    chk({"R8 feacValid ", ig}, feacValid, eFeac);
    if (eFeac) chk("R8 feacBit", feacBit, expFeacBit);
    chk({"R9 dlValid ", ig}, dlValid, eDl);
    if (eDl) chk("R9 dlBit", dlBit, expDlBit);
  endtask

  task automatic field(int sub, bit [2:0] v, bit inF, bit lp);
    for (int i = 1; i <= 3; i++) slot(sub, i, v[3 - i], inF, lp, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rxBit = 0; slotStb = 0; slotSub = 0; slotIdx = 0;
    inFrame = 0; localParity = 0; cntLatch = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 modeDet", modeDet, 0);
    chk("R1 cpValue", cpValue, 0);
    chk("R1 febeCount", febeCount, 0);
    chk("R1 pulses", {cpErr, febeErr, feacValid, dlValid, feacBit, dlBit}, 0);

    // R2 mode run, R10 out-of-frame sample neither advances nor breaks
    slot(1, 1, 1, 1, 0, 0);
    slot(1, 1, 1, 1, 0, 0);
    slot(1, 1, 0, 0, 0, 0);
    chk("R10 modeDet held low", modeDet, 0);
    slot(1, 1, 1, 1, 0, 0);
    chk("R2 modeDet set on third", modeDet, 1);
    slot(1, 1, 0, 1, 0, 0);
    slot(1, 1, 0, 1, 0, 0);
    slot(1, 1, 1, 1, 0, 0);
    slot(1, 1, 0, 1, 0, 0);
    slot(1, 1, 0, 1, 0, 0);
    chk("R2 modeDet kept after broken run", modeDet, 1);
    slot(1, 1, 0, 1, 0, 0);
    chk("R2 modeDet cleared", modeDet, 0);

    // R3/R4 majority and parity compare
    field(3, 3'b101, 1, 1);
    field(3, 3'b001, 1, 1);
    field(3, 3'b110, 1, 0);
    field(3, 3'b111, 0, 0);   // R10: no update, no pulse
    // R5/R6 far-end field
    field(4, 3'b111, 1, 0);
    field(4, 3'b000, 1, 0);
    field(4, 3'b101, 1, 0);
    // R7 clear wins over simultaneous increment
    slot(4, 1, 0, 1, 0, 0);
    slot(4, 2, 0, 1, 0, 0);
    slot(4, 3, 0, 1, 0, 1);
    chk("R7 clear beats increment", febeCount, 0);
    // R8/R9/R11
    slot(1, 3, 1, 1, 0, 0);
    slot(1, 3, 0, 1, 0, 0);
    field(5, 3'b101, 1, 0);
    field(5, 3'b011, 0, 0);
    field(2, 3'b010, 1, 0);
    field(6, 3'b111, 1, 0);
    field(7, 3'b000, 1, 0);
    slot(1, 2, 1, 1, 0, 0);
    // R6 saturation
    for (int n = 0; n < CMAX + 5; n++) field(4, 3'b000, 1, 0);
    chk("R6 saturated count", febeCount, CMAX);
    slot(2, 1, 0, 1, 0, 1);
    chk("R7 clear after saturation", febeCount, 0);

    // seeded random frames
    void'($urandom(32'h5eed_c0de));
    for (int f = 0; f < 400; f++) begin
      bit lp = $urandom_range(0, 1);
      for (int s = 1; s <= 7; s++)
        for (int i = 1; i <= 3; i++)
          slot(s, i, $urandom_range(0, 3) != 0, $urandom_range(0, 9) != 0, lp,
               $urandom_range(0, 59) == 0);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule